// File: doc/BRIEF.md
# Two-Master Bus Ownership Arbiter

This block decides which of two masters drives a shared system bus in each clock cycle. One master is a host processor with the lowest priority. The other is a data-move engine with the highest priority. Each master has a request line, a strobe that marks a safe point in its own bus activity, and a lock flag. The host also reports when it is asleep. Whoever owns the bus sees its acknowledge high and keeps the bus until that acknowledge is withdrawn.

Handover is never forced in the middle of an access. The host yields only at a break between its bus cycles, and never between the halves of a locked split access such as a longword done as two word cycles. While the host sleeps, a pending engine request is granted at once. The engine gives the bus back only after a complete phase: a vector fetch, a descriptor read, one data transfer, or a descriptor write-back. It then returns the bus to the host, which is the parked default owner whenever nobody else holds the bus.

Top module: `bus_arb_top`

## Requirements
- R1: During and right after reset, `host_ack` is 1, `xfer_ack` is 0 and `bus_owner` is 0.
- R2: In every cycle exactly one of `host_ack` and `xfer_ack` is 1, and `bus_owner` is 1 exactly when `xfer_ack` is 1 (0 means host, 1 means engine).
- R3: While the host owns the bus, a clock edge with `xfer_req`=1, `host_bnd`=1 and `host_lock`=0 moves ownership to the engine. The new acknowledge rises in the same cycle in which `host_ack` falls, one edge after the condition.
- R4: While the host owns the bus and `host_lock` is 1, `host_bnd` is ignored and the host keeps the bus (unless R6 applies).
- R5: While the host owns the bus, is awake and `host_bnd` is 0, an engine request does not take the bus.
- R6: While the host owns the bus and `host_sleep` is 1, an engine request is granted on the next edge, whatever the values of `host_bnd` and `host_lock`.
- R7: While the engine owns the bus, it keeps the bus through every edge on which `xfer_bnd` is 0, even when `xfer_req` has fallen.
- R8: While the engine owns the bus and `xfer_lock` is 1, `xfer_bnd` is ignored and the engine keeps the bus.
- R9: While the engine owns the bus, an edge with `xfer_bnd`=1, `xfer_lock`=0 and `xfer_req`=0 returns the bus to the host.
- R10: At a phase end, an engine that still requests keeps the bus, whatever the value of `host_req`.
- R11: With `xfer_req` at 0, the host stays the owner whether `host_req` is high or low. The engine is never granted the bus while its request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host asks for the bus |
| host_bnd | input | 1 | Host is at a break between bus cycles |
| host_lock | input | 1 | Host is inside a split access that must not be broken |
| host_sleep | input | 1 | Host is in sleep mode |
| xfer_req | input | 1 | Engine asks for the bus |
| xfer_bnd | input | 1 | Engine has just completed a phase |
| xfer_lock | input | 1 | Engine phases are chained; do not release yet |
| host_ack | output | 1 | Host owns the bus |
| xfer_ack | output | 1 | Engine owns the bus |
| bus_owner | output | 1 | Current owner: 0 host, 1 engine |

## Verification
Directed steps first walk the host-side gate. An engine request arrives with no boundary, then with a boundary under lock, then with a clean boundary. This separates a gate that waits correctly from one that ignores the lock or the strobe. The engine side is then taken through a dropped request in mid-phase, a locked phase end, a phase end that is still requesting while the host also requests, and a final release. Each of these tells a proper phase-boundary release apart from an early or a missing one. A sleep grant with lock high and no boundary checks that the sleep path bypasses both gates. Several thousand seeded random steps then mix every input, so that rare combinations such as sleep together with a boundary, or release racing a fresh request, are each checked against the bench's model.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [0:0] {
        OWN_HOST = 1'b0,
        OWN_XFER = 1'b1
    } owner_e;

    typedef struct packed {
        owner_e owner;
    } arb_state_t;

endpackage

// File: rtl/bus_arb_host_gate.sv
// Decides whether the host may give up the bus on the coming edge.
module bus_arb_host_gate (
    input  logic host_bnd,
    input  logic host_lock,
    input  logic host_sleep,
    output logic yield_ok
);
    logic clean_break;

    always_comb begin
        // a boundary inside a locked split access does not count
        clean_break = host_bnd & ~host_lock;
        // a sleeping host holds no cycle open, so it yields at once
        yield_ok    = host_sleep | clean_break;
    end
endmodule

// File: rtl/bus_arb_xfer_gate.sv
// Decides whether the engine has reached a point where it may let go.
module bus_arb_xfer_gate (
    input  logic xfer_bnd,
    input  logic xfer_lock,
    output logic phase_done
);
    always_comb begin
        phase_done = xfer_bnd & ~xfer_lock;
    end
endmodule

// File: rtl/bus_arb_core.sv
module bus_arb_core
    import bus_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   host_req,
    input  logic   xfer_req,
    input  logic   host_yield,
    input  logic   xfer_done,
    output owner_e owner
);
    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.owner)
            OWN_HOST: begin
                if (xfer_req && host_yield) st_d.owner = OWN_XFER;
            end
            OWN_XFER: begin
                // engine keeps the bus at a phase end while it still requests
                if (xfer_done && !xfer_req) st_d.owner = OWN_HOST;
            end
            default: st_d.owner = OWN_HOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: OWN_HOST};
        else        st_q <= st_d;
    end

    assign owner = st_q.owner;

    // host requests never pull the bus from a requesting engine
    assert_host_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_XFER && xfer_req && host_req) |=> (owner == OWN_XFER));
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic host_bnd,
    input  logic host_lock,
    input  logic host_sleep,
    input  logic xfer_req,
    input  logic xfer_bnd,
    input  logic xfer_lock,
    output logic host_ack,
    output logic xfer_ack,
    output logic bus_owner
);
    logic   host_yield;
    logic   xfer_done;
    owner_e owner;

    bus_arb_host_gate u_host_gate (
        .host_bnd  (host_bnd),
        .host_lock (host_lock),
        .host_sleep(host_sleep),
        .yield_ok  (host_yield)
    );

    bus_arb_xfer_gate u_xfer_gate (
        .xfer_bnd  (xfer_bnd),
        .xfer_lock (xfer_lock),
        .phase_done(xfer_done)
    );

    bus_arb_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .xfer_req  (xfer_req),
        .host_yield(host_yield),
        .xfer_done (xfer_done),
        .owner     (owner)
    );

    always_comb begin
        host_ack  = (owner == OWN_HOST);
        xfer_ack  = (owner == OWN_XFER);
        bus_owner = owner;
    end

    // locked split access is never broken by an awake host's boundary
    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_lock && !host_sleep) |=> host_ack);

    // no boundary, no sleep: the host keeps the bus
    assert_wait_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !host_bnd && !host_sleep) |=> host_ack);

    // sleeping host hands over on the next edge
    assert_sleep_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_sleep && xfer_req) |=> xfer_ack);

    // engine never lets go mid-phase
    assert_no_mid_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !(xfer_bnd && !xfer_lock)) |=> xfer_ack);

    // finished and idle engine returns the bus
    assert_return_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && xfer_bnd && !xfer_lock && !xfer_req) |=> host_ack);

    // engine is granted only when it asked on that edge
    assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_ack) |-> $past(xfer_req));

    // the handover swaps both acknowledges in one cycle
    assert_swap_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ack) |-> $rose(xfer_ack));
endmodule

// File: tb/bus_arb_top_tb.sv
module bus_arb_top_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic host_req, host_bnd, host_lock, host_sleep;
    logic xfer_req, xfer_bnd, xfer_lock;
    logic host_ack, xfer_ack, bus_owner;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;
    bit  exp_x  = 1'b0;   // expected owner: 1 = engine
    int  seed   = 32'h5eed_1234;

    always #4 clk = ~clk;  // 125 MHz

    bus_arb_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_bnd(host_bnd), .host_lock(host_lock),
        .host_sleep(host_sleep), .xfer_req(xfer_req), .xfer_bnd(xfer_bnd),
        .xfer_lock(xfer_lock), .host_ack(host_ack), .xfer_ack(xfer_ack),
        .bus_owner(bus_owner)
    );

    function automatic bit next_owner(bit cur, bit xr, bit hb, bit hl, bit hs,
                                      bit xb, bit xl);
        if (!cur) return xr && (hs || (hb && !hl));
        return !(xb && !xl && !xr);
    endfunction

    function automatic string rule_tag(bit cur, bit xr, bit hb, bit hl, bit hs,
                                       bit xb, bit xl);
        if (!cur) begin
            if (xr && hs)  return "R6";
            if (!xr)       return "R11";
            if (hb && hl)  return "R4";
            if (!hb)       return "R5";
            return "R3";
        end
        if (xb && !xl && !xr) return "R9";
        if (xb && !xl)        return "R10";
        if (xb)               return "R8";
        return "R7";
    endfunction

    task automatic check(string tag, bit ex);
        n_vec++;
        if ({host_ack, xfer_ack, bus_owner} !== {~ex, ex, ex}) begin
            n_bad++;
            $display("FAIL %s: host_ack/xfer_ack/owner = %b%b%b expected %b%b%b",
                     tag, host_ack, xfer_ack, bus_owner, ~ex, ex, ex);
        end
        // R2: exactly one acknowledge, owner agrees with it
        n_vec++;
        if ((host_ack ^ xfer_ack) !== 1'b1 || bus_owner !== xfer_ack) begin
            n_bad++;
            $display("FAIL R2: acks %b%b owner %b expected one-hot with owner=xfer_ack",
                     host_ack, xfer_ack, bus_owner);
        end
    endtask

    // inputs change at the falling edge; outputs are read one falling edge later
    task automatic step(bit hr, bit hb, bit hl, bit hs, bit xr, bit xb, bit xl);
        string tag;
        host_req = hr; host_bnd = hb; host_lock = hl; host_sleep = hs;
        xfer_req = xr; xfer_bnd = xb; xfer_lock = xl;
        tag = rule_tag(exp_x, xr, hb, hl, hs, xb, xl);
        @(posedge clk);
        exp_x = next_owner(exp_x, xr, hb, hl, hs, xb, xl);
        @(negedge clk);
        check(tag, exp_x);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {host_req, host_bnd, host_lock, host_sleep, xfer_req, xfer_bnd, xfer_lock} = '0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // directed walk: hr hb hl hs xr xb xl
        step(1, 0, 0, 0, 0, 0, 0);   // R11 host requests, parked host
        step(0, 1, 0, 0, 0, 1, 0);   // R11 idle with strobes, still host
        step(1, 0, 0, 0, 1, 0, 0);   // R5 no boundary
        step(1, 1, 1, 0, 1, 0, 0);   // R4 boundary under lock
        step(1, 1, 0, 0, 1, 0, 0);   // R3 clean boundary -> engine
        step(1, 0, 0, 0, 0, 0, 0);   // R7 request dropped mid-phase
        step(1, 0, 0, 0, 0, 1, 1);   // R8 locked phase end
        step(1, 0, 0, 0, 1, 1, 0);   // R10 still requesting at phase end
        step(0, 0, 0, 0, 0, 1, 0);   // R9 release -> host
        step(0, 0, 1, 1, 1, 0, 0);   // R6 sleeping host, lock high, no boundary
        step(0, 0, 0, 0, 0, 1, 0);   // R9 back to host
        step(0, 1, 1, 1, 1, 0, 0);   // R6 sleep beats lock with a boundary
        step(0, 0, 0, 0, 0, 1, 0);   // R9

        void'($urandom(seed));
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 7, ($urandom % 10) < 4, ($urandom % 10) < 3,
                 ($urandom % 10) < 1, ($urandom % 2) == 1, ($urandom % 10) < 4,
                 ($urandom % 10) < 3);
        end
        finish_run();
    end
endmodule